// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces a pulse-width modulated output whose period is set by a wrapping phase accumulator rather than by a counter that compares against a terminal value. On every clock edge a programmable increment is added, modulo 2^ACC_W, to an ACC_W-bit accumulator. Each carry out of the accumulator ends one PWM period. The output frequency is therefore proportional to the increment: it equals the clock frequency times increment / 2^ACC_W.

An 8-bit on-time value, on a 0 to 255 scale, sets the fraction of each period during which the output is high. Both settings arrive together in one control word through a single-cycle write strobe. A write first lands in a staging register and is applied only at the next accumulator wrap, so a period already in progress keeps its length and its duty. An increment of zero stops the accumulator and holds the output low. While the active increment is zero, a new write is applied on the next clock edge, because no wrap would ever come to apply it.

Top module: `pwm_phase_gen`

## Requirements
- R1: A synchronous reset, active low, clears the accumulator, the staged and active settings, `pwm_out` and `period_start` to 0. After reset and before any write, the output stays low and no period starts.
- R2: Bits [7:0] of `wr_data` hold the on-time and bits [8+INC_W-1:8] hold the increment. A write with `wr_en` high replaces both fields at once.
- R3: While the active increment is 0, the accumulator holds its value, `pwm_out` is 0, and no new period starts.
- R4: On each clock edge the accumulator advances by the active increment, modulo 2^ACC_W. Over any 2^ACC_W consecutive cycles with a constant increment, exactly that many wraps occur. The maximum increment, 2^INC_W-1, is accepted unchanged and gives the highest output frequency.
- R5: `period_start` is high for exactly the one cycle following each clock edge at which the accumulator carried out, and is low in every other cycle.
- R6: `pwm_out` is a registered output. It is 1 exactly when the active increment is non-zero and the top 8 bits of the accumulator are below the active on-time. With increment 1, this gives 2^(ACC_W-8) x on-time high cycles per period.
- R7: An on-time of 0 keeps `pwm_out` low. An on-time of 255 drives it low only while the top 8 accumulator bits are all ones.
- R8: A written control word becomes active at the next wrap, so neither the period in progress nor its duty changes. If the active increment is 0, the word becomes active on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8+INC_W | Control word: on-time in [7:0], increment above it |
| pwm_out | output | 1 | Registered PWM output |
| period_start | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench sweeps a 10-bit accumulator across a grid of increments and on-times. The grid includes increment 0, increment 1, and the maximum increment 1023, which nearly wraps on every cycle. A design that masked or truncated the increment would produce the wrong number of wraps in a 1024-cycle window. A design that forgot the zero-increment gate would drive the output high while the accumulator is frozen below the on-time. The bench also writes a new on-time in the middle of a period: a design that applied it at once would change the output before the wrap. A design that only ever loaded at a wrap would stay stuck forever after reset, because the increment starts at zero and no wrap ever arrives.

// File: rtl/pwm_phase_pkg.sv
// Package: shared constants for the phase-accumulator PWM.
// Assumes: the on-time field is always 8 bits wide and sits at the bottom of the control word.
package pwm_phase_pkg;
    localparam int DUTY_W = 8;
endpackage

// File: rtl/pwm_ctrl_stage.sv
// Module: staging and active copies of the control word.
// A write lands in the staging register. The staged word moves to the active
// copy at an accumulator wrap, or on any edge while the active increment is zero.
// Assumes: wr_data is stable across the edge at which wr_en is high.
module pwm_ctrl_stage
    import pwm_phase_pkg::*;
#(
    parameter int INC_W = 16,
    localparam int CTRL_W = DUTY_W + INC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wrap,
    output logic [INC_W-1:0]  inc_act,
    output logic [DUTY_W-1:0] duty_act,
    output logic [INC_W-1:0]  inc_nxt,
    output logic [DUTY_W-1:0] duty_nxt
);
    logic [INC_W-1:0]  inc_stg;
    logic [DUTY_W-1:0] duty_stg;
    logic              load;

    // Purpose: choose when the staged word becomes active.
    always_comb begin
        load     = wrap || (inc_act == '0);
        inc_nxt  = load ? inc_stg  : inc_act;
        duty_nxt = load ? duty_stg : duty_act;
    end

    // Purpose: capture software writes into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_stg  <= '0;
            duty_stg <= '0;
        end else if (wr_en) begin
            inc_stg  <= wr_data[CTRL_W-1:DUTY_W];
            duty_stg <= wr_data[DUTY_W-1:0];
        end
    end

    // Purpose: hold the settings that drive the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_act  <= '0;
            duty_act <= '0;
        end else begin
            inc_act  <= inc_nxt;
            duty_act <= duty_nxt;
        end
    end
endmodule

// File: rtl/pwm_phase_acc.sv
// Module: phase accumulator with carry detection.
// Adds the active increment to the accumulator on every edge, modulo 2^ACC_W.
// The carry out ends a period.
// Assumes: INC_W <= ACC_W, and the increment is zero-extended.
module pwm_phase_acc #(
    parameter int ACC_W = 16,
    parameter int INC_W = 16,
    localparam int PAD_W = ACC_W + 1 - INC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_act,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             wrap,
    output logic             period_start
);
    logic [ACC_W:0] sum;

    // Purpose: form the next phase and the carry out.
    always_comb begin
        sum     = {1'b0, acc} + {{PAD_W{1'b0}}, inc_act};
        acc_nxt = sum[ACC_W-1:0];
        wrap    = sum[ACC_W];
    end

    // Purpose: advance the phase and flag the start of a new period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc          <= '0;
            period_start <= 1'b0;
        end else begin
            acc          <= acc_nxt;
            period_start <= wrap;
        end
    end
endmodule

// File: rtl/pwm_duty_out.sv
// Module: duty comparator and output register.
// Compares the top 8 bits of the next phase with the next on-time and registers
// the result, so the output has no combinational glitches.
// Assumes: ACC_W >= 8.
module pwm_duty_out
    import pwm_phase_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc_nxt,
    input  logic              run_nxt,
    input  logic [DUTY_W-1:0] duty_nxt,
    output logic              pwm_out
);
    logic [DUTY_W-1:0] phase_top;

    // Purpose: take the coarse phase used for the duty compare.
    always_comb phase_top = acc_nxt[ACC_W-1 -: DUTY_W];

    // Purpose: register the compare result; a zero increment forces low.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= run_nxt && (phase_top < duty_nxt);
    end
endmodule

// File: rtl/pwm_phase_gen.sv
// Module: top of the phase-accumulator PWM generator.
// Wires the control staging, the accumulator and the output stage together.
// Assumes: INC_W <= ACC_W and ACC_W >= 8.
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int INC_W = ACC_W,
    localparam int CTRL_W = DUTY_W + INC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              period_start
);
    logic [INC_W-1:0]  inc_act;
    logic [INC_W-1:0]  inc_nxt;
    logic [DUTY_W-1:0] duty_act;
    logic [DUTY_W-1:0] duty_nxt;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_nxt;
    logic              wrap;
    logic              run_nxt;

    // Purpose: the output may run only when the next increment is non-zero.
    always_comb run_nxt = (inc_nxt != '0);

    pwm_ctrl_stage #(.INC_W(INC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wrap(wrap), .inc_act(inc_act), .duty_act(duty_act),
        .inc_nxt(inc_nxt), .duty_nxt(duty_nxt)
    );

    pwm_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .inc_act(inc_act), .acc(acc),
        .acc_nxt(acc_nxt), .wrap(wrap), .period_start(period_start)
    );

    pwm_duty_out #(.ACC_W(ACC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .acc_nxt(acc_nxt), .run_nxt(run_nxt),
        .duty_nxt(duty_nxt), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_phase_gen_chk.sv
// Module: assertion checker bound into pwm_phase_gen.
// Observes the active settings, the phase and the outputs.
// Assumes: every property is evaluated only while reset is inactive.
module pwm_phase_gen_chk
    import pwm_phase_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int INC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INC_W-1:0]  inc_act,
    input logic [DUTY_W-1:0] duty_act,
    input logic [ACC_W-1:0]  acc,
    input logic              pwm_out,
    input logic              period_start
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (acc == '0 && inc_act == '0 && !pwm_out && !period_start));

    assert_zero_inc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_act == '0) |-> !pwm_out);

    assert_acc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (acc == $past(acc + ACC_W'(inc_act))));

    assert_wrap_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (period_start == ($past(inc_act) != '0 && acc < $past(acc))));

    assert_duty_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out == (inc_act != '0 && acc[ACC_W-1 -: DUTY_W] < duty_act));

    assert_duty_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_out);

    assert_hold_mid_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !period_start && $past(inc_act) != '0)
            |-> ($stable(inc_act) && $stable(duty_act)));
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.ACC_W(ACC_W), .INC_W(INC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inc_act(inc_act), .duty_act(duty_act),
    .acc(acc), .pwm_out(pwm_out), .period_start(period_start)
);

// File: tb/tb_pwm_phase_gen.sv
// Bench: sweeps a 10-bit configuration. Window counts are derived arithmetically;
// a cycle model built from the requirements is compared on every falling edge.
module tb_pwm_phase_gen;
    localparam int ACC_W  = 10;
    localparam int INC_W  = 10;
    localparam int CTRL_W = 8 + INC_W;
    localparam int SPAN   = 1 << ACC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [CTRL_W-1:0] wr_data = '0;
    logic              pwm_out;
    logic              period_start;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    logic [ACC_W-1:0] m_acc;
    logic [INC_W-1:0] m_inc, m_pinc;
    logic [7:0]       m_duty, m_pduty;
    logic             m_out, m_ps;

    always #10 clk = ~clk;

    pwm_phase_gen #(.ACC_W(ACC_W), .INC_W(INC_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pwm_out(pwm_out), .period_start(period_start)
    );

    // reference model from the requirements (R4, R5, R6, R8)
    always @(posedge clk) begin
        logic [ACC_W:0]   s;
        logic             ld;
        logic [INC_W-1:0] ni;
        logic [7:0]       nd;
        if (!rst_n) begin
            m_acc <= '0; m_inc <= '0; m_duty <= '0; m_pinc <= '0; m_pduty <= '0;
            m_out <= 1'b0; m_ps <= 1'b0;
        end else begin
            s  = {1'b0, m_acc} + (ACC_W+1)'(m_inc);
            ld = s[ACC_W] || (m_inc == '0);
            ni = ld ? m_pinc : m_inc;
            nd = ld ? m_pduty : m_duty;
            m_acc  <= s[ACC_W-1:0];
            m_inc  <= ni;
            m_duty <= nd;
            m_ps   <= s[ACC_W];
            m_out  <= (ni != '0) && (s[ACC_W-1 -: 8] < nd);
            if (wr_en) begin
                m_pinc  <= wr_data[CTRL_W-1:8];
                m_pduty <= wr_data[7:0];
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(pwm_out == m_out, "R6 pwm_out", pwm_out, m_out);
            check(period_start == m_ps, "R5 period_start", period_start, m_ps);
        end
        if (cycles > 190000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic write_word(input int inc, input int duty);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {INC_W'(inc), 8'(duty)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic window(input int n, output int wraps, output int highs);
        wraps = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wraps += int'(period_start);
            highs += int'(pwm_out);
        end
    endtask

    initial begin
        int wraps, highs;
        int incs[8]  = '{0, 1, 2, 3, 7, 100, 511, 1023};
        int duties[5] = '{0, 1, 64, 128, 255};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(pwm_out == 1'b0, "R1 pwm_out in reset", pwm_out, 0);
        check(period_start == 1'b0, "R1 period_start in reset", period_start, 0);
        rst_n = 1'b1;
        window(SPAN, wraps, highs);
        check(wraps == 0, "R1 no period after reset", wraps, 0);
        check(highs == 0, "R1 low after reset", highs, 0);

        // R8: zero active increment takes a write on the next edge; R2 field split
        write_word(5, 255);
        @(negedge clk);
        check(pwm_out == 1'b1, "R8 immediate load from zero increment", pwm_out, 1);

        // sweep: R2, R3, R4, R6, R7
        foreach (incs[i]) begin
            foreach (duties[j]) begin
                write_word(incs[i], duties[j]);
                repeat (SPAN + 4) @(negedge clk);
                window(SPAN, wraps, highs);
                check(wraps == incs[i], "R4 wraps per window", wraps, incs[i]);
                if (incs[i] == 0)
                    check(highs == 0, "R3 zero increment keeps low", highs, 0);
                if (duties[j] == 0)
                    check(highs == 0, "R7 zero on-time keeps low", highs, 0);
                if (incs[i] == 1)
                    check(highs == 4 * duties[j], "R6 high cycles with increment 1",
                          highs, 4 * duties[j]);
                if (incs[i] == 1 && duties[j] == 255)
                    check(highs == SPAN - 4, "R7 full on-time", highs, SPAN - 4);
            end
        end

        // R8: a mid-period write waits for the wrap
        write_word(1, 128);
        repeat (SPAN + 4) @(negedge clk);
        @(posedge period_start);
        repeat (100) @(negedge clk);
        write_word(1, 16);
        repeat (100) @(negedge clk);
        check(pwm_out == 1'b1, "R8 old on-time holds mid-period", pwm_out, 1);
        @(posedge period_start);
        repeat (200) @(negedge clk);
        check(pwm_out == 1'b0, "R8 new on-time after wrap", pwm_out, 0);

        // R1: reset in the middle of a run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0 && period_start == 1'b0, "R1 mid-run reset",
              {pwm_out, period_start}, 0);
        rst_n = 1'b1;
        window(SPAN, wraps, highs);
        check(wraps == 0 && highs == 0, "R1 settings cleared by reset", wraps + highs, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule